// File: doc/BRIEF.md
# Rotating-Priority Interrupt Controller

The controller collects 64 interrupt inputs and turns them into eight request outputs: a normal interrupt line, a fast interrupt line and six auxiliary lines. A single control byte per input decides three things. It decides whether the input may raise a request, whether the input is watched as an active-high level or for edges, and which of the eight outputs the input drives. Edge events are latched in two 32-bit status words and stay there until software clears them by writing ones. Level inputs appear in the same words without being latched.

For the normal interrupt line the controller also picks one winner among the enabled, pending inputs routed to it and presents the winner's number in a readable register. Arbitration is either fixed, where the lowest number wins, or rotating. In rotating mode each read of the winner register moves that source to the back of the queue. When nothing is pending the register holds 63. Software tells a real source 63 from an idle controller by looking at the top bit of the second status word.

Software reaches every register through a simple aligned 32-bit bus with per-byte write strobes. Reads are combinational, and a write takes effect at the clock edge on which it is presented.

Top module: `rotIntCtl`

## Requirements
- R1: After reset every control byte is 0 (all inputs disabled and routed to the normal line), rotation is off, every status bit is 0, all request outputs are low and the winner register reads 63.
- R2: The control byte of input n sits at byte address 0x40+n, in lane n%4 of the word at 0x40+4*(n/4). Only lanes whose write strobe is set change, and the word reads back with the same layout. Bit 3 of the byte is the enable.
- R3: With bits 5 and 6 both clear, an input works as an active-high level. Its status bit follows the input through a two-flop synchronizer: a change made before clock edge k appears after edge k+1.
- R4: Bit 5 records rising edges, bit 6 records falling edges, and both together record either. A recorded edge sets the status bit after the third clock edge following the input change. Edges are recorded even when the enable bit is clear.
- R5: An edge status bit stays set until a 1 is written to it. Input n maps to bit n%32 of the word at 0x80 (n<32) or 0x84 (n>=32). Writing 1 to the bit of a level-mode input has no effect.
- R6: Control byte bits 2:0 select the output: 0 normal line, 1 fast line, 2 to 7 auxiliary lines 0 to 5. Each output is high while any enabled input with its status bit set is routed to it.
- R7: Reading address 0x00 returns the winner number in bits 5:0 with upper bits zero. Under fixed priority the winner is the lowest-numbered enabled, pending input routed to the normal line.
- R8: When no enabled, pending input is routed to the normal line, address 0x00 reads 63. Bit 31 of the word at 0x84 is 1 only when input 63 itself has its status set.
- R9: Bit 6 of the word at 0x20 turns on rotation. Each read of 0x00 while the normal line is high makes the returned source the lowest priority, and the next search starts one number above it, wrapping after 63.
- R10: Bits 6:0 of the words at 0x20 (normal line) and 0x24 (fast line) are writable through lane 0 and read back with the upper bits zero. Unmapped aligned addresses read 0.
- R11: A disabled input never drives an output and is never chosen as the winner, whatever its status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srcIn | input | 64 | Raw interrupt inputs, asynchronous to clk |
| addr | input | 8 | Byte address of the access, word aligned |
| wrEn | input | 1 | Write strobe for one cycle |
| rdEn | input | 1 | Read strobe for one cycle (a read of 0x00 acknowledges the winner) |
| wstrb | input | 4 | Byte lane enables for writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| irqReq | output | 1 | Normal interrupt request |
| fiqReq | output | 1 | Fast interrupt request |
| auxReq | output | 6 | Auxiliary interrupt requests |

## Verification
A level input reaches its status bit, the outputs and the winner two clock edges after it changes. An edge input needs three edges. Control-byte and status writes act at the edge that takes the write. Read data is valid in the same cycle as the address. The bench drives inputs on falling edges. It checks the exact latency once for level mode and once for edge mode by sampling one cycle before and at the due cycle. Elsewhere it waits at least four cycles before sampling. The winner reads are taken before the rising edge that acknowledges them, so every expected rotation order is computed from the previous returned value.

// File: rtl/rotIntPkg.sv
package rotIntPkg;

  localparam int NUM_DEST  = 8;
  localparam int EN_BIT    = 3;
  localparam int RISE_BIT  = 5;
  localparam int FALL_BIT  = 6;
  localparam int ROT_BIT   = 6;
  localparam int DEST_IRQ  = 0;
  localparam int DEST_FIQ  = 1;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_WINNER,
    RD_PRIO_IRQ,
    RD_PRIO_FIQ,
    RD_CTL,
    RD_STAT
  } rdSel_t;

  typedef struct packed {
    logic       wrCtl;
    logic       wrStat;
    logic       wrPrioIrq;
    logic       wrPrioFiq;
    logic       ackWinner;
    logic [3:0] wordIdx;
    logic [3:0] laneEn;
    rdSel_t     rdSel;
  } strobes_t;

endpackage

// File: rtl/rotIntDecode.sv
module rotIntDecode
  import rotIntPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [3:0]        wstrb,
  output strobes_t          strobes
);

  localparam int WADDR_W = ADDR_W - 2;

  logic               aligned;
  logic [WADDR_W-1:0] wAddr;
  logic               inCtl;
  logic               inStat;
  logic               isWinner;
  logic               isPrioIrq;
  logic               isPrioFiq;

  assign aligned   = (addr[1:0] == 2'b00);
  assign wAddr     = addr[ADDR_W-1:2];
  assign inCtl     = aligned && (wAddr >= WADDR_W'(8'h40 >> 2)) && (wAddr < WADDR_W'(8'h80 >> 2));
  assign inStat    = aligned && (wAddr >= WADDR_W'(8'h80 >> 2)) && (wAddr < WADDR_W'(8'h88 >> 2));
  assign isWinner  = aligned && (wAddr == WADDR_W'(0));
  assign isPrioIrq = aligned && (wAddr == WADDR_W'(8'h20 >> 2));
  assign isPrioFiq = aligned && (wAddr == WADDR_W'(8'h24 >> 2));

  always_comb begin
    strobes           = '0;
    strobes.wordIdx   = wAddr[3:0];
    strobes.laneEn    = wstrb;
    strobes.wrCtl     = wrEn && inCtl;
    strobes.wrStat    = wrEn && inStat;
    strobes.wrPrioIrq = wrEn && isPrioIrq;
    strobes.wrPrioFiq = wrEn && isPrioFiq;
    strobes.ackWinner = rdEn && isWinner;
    if (isWinner)       strobes.rdSel = RD_WINNER;
    else if (isPrioIrq) strobes.rdSel = RD_PRIO_IRQ;
    else if (isPrioFiq) strobes.rdSel = RD_PRIO_FIQ;
    else if (inCtl)     strobes.rdSel = RD_CTL;
    else if (inStat)    strobes.rdSel = RD_STAT;
    else                strobes.rdSel = RD_NONE;
  end

endmodule

// File: rtl/rotIntArbiter.sv
module rotIntArbiter #(
  parameter int NUM_SRC = 64,
  parameter int SRC_W   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] req,
  input  logic               rotate,
  input  logic [SRC_W-1:0]   lastRep,
  output logic               found,
  output logic [SRC_W-1:0]   winner
);

  localparam logic [SRC_W-1:0] LAST_IDX = SRC_W'(NUM_SRC - 1);
  localparam logic [SRC_W:0]   N_EXT    = (SRC_W+1)'(NUM_SRC);

  logic [SRC_W-1:0] startIdx;
  logic [SRC_W-1:0] pick;

  assign startIdx = (rotate && (lastRep != LAST_IDX)) ? lastRep + SRC_W'(1) : '0;

  always_comb begin
    logic [SRC_W:0] idx;
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      idx = {1'b0, startIdx} + (SRC_W+1)'(i);
      if (idx >= N_EXT) idx = idx - N_EXT;
      if (!found && req[idx[SRC_W-1:0]]) begin
        found = 1'b1;
        pick  = idx[SRC_W-1:0];
      end
    end
  end

  assign winner = found ? pick : LAST_IDX;

endmodule

// File: rtl/rotIntCore.sv
module rotIntCore
  import rotIntPkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int NUM_AUX = NUM_DEST - 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  strobes_t           strobes,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  output logic               irqReq,
  output logic               fiqReq,
  output logic [NUM_AUX-1:0] auxReq,
  output logic [NUM_SRC-1:0] statVec,
  output logic [NUM_SRC-1:0] edgeVec
);

  localparam int SRC_W    = $clog2(NUM_SRC);
  localparam int PRIO_W   = 7;

  logic [8*NUM_SRC-1:0]  ctlFlat;
  logic [NUM_SRC-1:0]    pendVec;
  logic [NUM_DEST-1:0]   destReq;
  logic [NUM_SRC-1:0]    irqPend;
  logic [PRIO_W-1:0]     prioIrq;
  logic [PRIO_W-1:0]     prioFiq;
  logic [SRC_W-1:0]      lastRep;
  logic [SRC_W-1:0]      winner;
  logic                  winFound;

  // Per-source slice: control byte, synchronizer, edge latch, status.
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    localparam int WORD = s / 4;
    localparam int LANE = s % 4;
    localparam int SWRD = s / 32;
    localparam int SBIT = s % 32;

    logic [7:0] ctlReg;
    logic       syncA, syncB, syncC;
    logic       edgeLatch;
    logic       isEdge;
    logic       edgeHit;
    logic       clrHit;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ctlReg <= '0;
      end else if (strobes.wrCtl && strobes.wordIdx == 4'(WORD) && strobes.laneEn[LANE]) begin
        ctlReg <= wdata[8*LANE +: 8];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA <= 1'b0;
        syncB <= 1'b0;
        syncC <= 1'b0;
      end else begin
        syncA <= srcIn[s];
        syncB <= syncA;
        syncC <= syncB;
      end
    end

    assign isEdge  = ctlReg[RISE_BIT] | ctlReg[FALL_BIT];
    assign edgeHit = (ctlReg[RISE_BIT] & syncB & ~syncC) |
                     (ctlReg[FALL_BIT] & ~syncB & syncC);
    assign clrHit  = strobes.wrStat && (strobes.wordIdx[0] == 1'(SWRD)) &&
                     strobes.laneEn[SBIT/8] && wdata[SBIT];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         edgeLatch <= 1'b0;
      else if (!isEdge)  edgeLatch <= 1'b0;
      else if (edgeHit)  edgeLatch <= 1'b1;
      else if (clrHit)   edgeLatch <= 1'b0;
    end

    assign ctlFlat[8*s +: 8] = ctlReg;
    assign statVec[s]        = isEdge ? edgeLatch : syncB;
    assign edgeVec[s]        = isEdge;
    assign pendVec[s]        = ctlReg[EN_BIT] & statVec[s];
  end

  // Destination fan-in: each output ORs the enabled pending sources routed to it.
  always_comb begin
    destReq = '0;
    irqPend = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      for (int d = 0; d < NUM_DEST; d++) begin
        if (pendVec[s] && (ctlFlat[8*s +: 3] == 3'(d))) destReq[d] = 1'b1;
      end
      irqPend[s] = pendVec[s] && (ctlFlat[8*s +: 3] == 3'(DEST_IRQ));
    end
  end

  assign irqReq = destReq[DEST_IRQ];
  assign fiqReq = destReq[DEST_FIQ];
  assign auxReq = destReq[NUM_DEST-1:2];

  rotIntArbiter #(
    .NUM_SRC(NUM_SRC),
    .SRC_W  (SRC_W)
  ) u_arb (
    .req    (irqPend),
    .rotate (prioIrq[ROT_BIT]),
    .lastRep(lastRep),
    .found  (winFound),
    .winner (winner)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prioIrq <= '0;
      prioFiq <= '0;
      lastRep <= SRC_W'(NUM_SRC - 1);
    end else begin
      if (strobes.wrPrioIrq && strobes.laneEn[0]) prioIrq <= wdata[PRIO_W-1:0];
      if (strobes.wrPrioFiq && strobes.laneEn[0]) prioFiq <= wdata[PRIO_W-1:0];
      if (strobes.ackWinner && winFound)           lastRep <= winner;
    end
  end

  always_comb begin
    rdata = '0;
    case (strobes.rdSel)
      RD_WINNER:   rdata[SRC_W-1:0]  = winner;
      RD_PRIO_IRQ: rdata[PRIO_W-1:0] = prioIrq;
      RD_PRIO_FIQ: rdata[PRIO_W-1:0] = prioFiq;
      RD_CTL: begin
        for (int b = 0; b < 4; b++) begin
          rdata[8*b +: 8] = ctlFlat[8*{strobes.wordIdx, 2'(b)} +: 8];
        end
      end
      RD_STAT:     rdata = statVec[32*strobes.wordIdx[0] +: 32];
      default:     rdata = '0;
    endcase
  end

endmodule

// File: rtl/rotIntCtl.sv
module rotIntCtl
  import rotIntPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [63:0] srcIn,
  input  logic [7:0]  addr,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [3:0]  wstrb,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irqReq,
  output logic        fiqReq,
  output logic [5:0]  auxReq
);

  strobes_t    strobes;
  logic [63:0] statVec;
  logic [63:0] edgeVec;

  rotIntDecode #(.ADDR_W(8)) u_dec (
    .addr   (addr),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .wstrb  (wstrb),
    .strobes(strobes)
  );

  rotIntCore #(.NUM_SRC(64), .NUM_AUX(6)) u_core (
    .clk    (clk),
    .rstN   (rstN),
    .srcIn  (srcIn),
    .strobes(strobes),
    .wdata  (wdata),
    .rdata  (rdata),
    .irqReq (irqReq),
    .fiqReq (fiqReq),
    .auxReq (auxReq),
    .statVec(statVec),
    .edgeVec(edgeVec)
  );

endmodule

// File: rtl/rotIntCheck.sv
module rotIntCheck (
  input logic        clk,
  input logic        rstN,
  input logic [7:0]  addr,
  input logic        wrEn,
  input logic        rdEn,
  input logic [31:0] rdata,
  input logic        irqReq,
  input logic        fiqReq,
  input logic [5:0]  auxReq,
  input logic [63:0] statVec,
  input logic [63:0] edgeVec
);

  // R1: while reset is applied the outputs are quiet on the next edge
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (!irqReq && !fiqReq && auxReq == 6'd0));

  // R8: idle normal line reads the sentinel
  a_r8_idle_sentinel: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 8'h00 && !irqReq) |-> (rdata == 32'd63));

  // R7: a reported winner has its status set and upper bits zero
  a_r7_winner_pending: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 8'h00 && irqReq) |-> (rdata[31:6] == 26'd0 && statVec[rdata[5:0]]));

  // R5: without any write, set edge status bits stay set
  a_r5_edge_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> (($past(statVec & edgeVec) & ~statVec) == 64'd0));

  // R6: any request needs some status bit set
  a_r6_req_needs_status: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq || fiqReq || auxReq != 6'd0) |-> (statVec != 64'd0));

endmodule

bind rotIntCtl rotIntCheck u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .addr   (addr),
  .wrEn   (wrEn),
  .rdEn   (rdEn),
  .rdata  (rdata),
  .irqReq (irqReq),
  .fiqReq (fiqReq),
  .auxReq (auxReq),
  .statVec(statVec),
  .edgeVec(edgeVec)
);

// File: tb/sim_rotIntCtl.sv
`timescale 1ns/1ps
module sim_rotIntCtl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] srcIn = '0;
  logic [7:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [3:0]  wstrb = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irqReq;
  logic        fiqReq;
  logic [5:0]  auxReq;

  int nChk = 0;
  int nErr = 0;

  always #2.5 clk = ~clk;

  rotIntCtl u0 (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .addr(addr), .wrEn(wrEn),
    .rdEn(rdEn), .wstrb(wstrb), .wdata(wdata), .rdata(rdata),
    .irqReq(irqReq), .fiqReq(fiqReq), .auxReq(auxReq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    addr = a; wdata = d; wstrb = s; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; wstrb = '0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic setCtl(input int src, input logic [7:0] val);
    busWrite(8'h40 + 8'(src & ~3), 32'(val) << (8 * (src % 4)), 4'b0001 << (src % 4));
  endtask

  task automatic statBit(input int src, output logic b);
    logic [31:0] w;
    busRead((src < 32) ? 8'h80 : 8'h84, w);
    b = w[src % 32];
  endtask

  task automatic clearAll();
    srcIn = '0;
    for (int w = 0; w < 16; w++) busWrite(8'h40 + 8'(4 * w), 32'h0, 4'hF);
    waitCyc(4);
    busWrite(8'h80, 32'hFFFF_FFFF, 4'hF);
    busWrite(8'h84, 32'hFFFF_FFFF, 4'hF);
    busWrite(8'h20, 32'h0, 4'hF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nErr++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", nChk, nErr);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic        b;
    int          last;
    int          expW;
    int          pend [3];

    pend[0] = 3; pend[1] = 10; pend[2] = 50;

    waitCyc(3);
    rstN = 1'b1;
    waitCyc(2);

    // R1 reset state
    check("R1 irqReq", 32'(irqReq), 0);
    check("R1 fiqReq", 32'(fiqReq), 0);
    check("R1 auxReq", 32'(auxReq), 0);
    busRead(8'h00, rd); check("R1 winner", rd, 63);
    busRead(8'h20, rd); check("R1 prio", rd, 0);
    busRead(8'h80, rd); check("R1 stat0", rd, 0);
    busRead(8'h84, rd); check("R1 stat1", rd, 0);
    for (int w = 0; w < 16; w++) begin
      busRead(8'h40 + 8'(4 * w), rd); check("R1 ctl word", rd, 0);
    end

    // R2 byte lanes
    busWrite(8'h44, 32'hAABB_CC08, 4'b0001);
    busRead(8'h44, rd); check("R2 single lane", rd, 32'h0000_0008);
    busWrite(8'h44, 32'h1122_3344, 4'b1010);
    busRead(8'h44, rd); check("R2 two lanes", rd, 32'h1100_3308);
    busWrite(8'h44, 32'h0, 4'hF);
    busRead(8'h44, rd); check("R2 word clear", rd, 0);

    // R3 level sweep with exact latency on source 0, R7 fixed winner
    for (int s = 0; s < 64; s++) begin
      setCtl(s, 8'h08);
      srcIn[s] = 1'b1;
      waitCyc(1);
      if (s == 0) check("R3 not yet after one edge", 32'(irqReq), 0);
      waitCyc(1);
      check("R3 level irq", 32'(irqReq), 1);
      busRead(8'h00, rd); check("R7 winner single", rd, 32'(s));
      statBit(s, b); check("R3 level status", 32'(b), 1);
      srcIn[s] = 1'b0;
      waitCyc(3);
      check("R3 level drop", 32'(irqReq), 0);
      statBit(s, b); check("R3 status drop", 32'(b), 0);
      setCtl(s, 8'h00);
    end

    // R11 disabled level source
    srcIn[12] = 1'b1;
    waitCyc(4);
    check("R11 disabled irq", 32'(irqReq), 0);
    busRead(8'h00, rd); check("R11 disabled winner", rd, 63);
    statBit(12, b); check("R11 status visible", 32'(b), 1);
    srcIn[12] = 1'b0;
    waitCyc(4);

    // R6 routing for every destination, R8 non-IRQ sources do not win
    for (int d = 0; d < 8; d++) begin
      setCtl(5, 8'(8'h08 | d));
      srcIn[5] = 1'b1;
      waitCyc(4);
      check("R6 irq route", 32'(irqReq), (d == 0) ? 1 : 0);
      check("R6 fiq route", 32'(fiqReq), (d == 1) ? 1 : 0);
      check("R6 aux route", 32'(auxReq), (d >= 2) ? (1 << (d - 2)) : 0);
      busRead(8'h00, rd); check("R8 winner by route", rd, (d == 0) ? 5 : 63);
      srcIn[5] = 1'b0;
      waitCyc(4);
      check("R6 aux release", 32'(auxReq), 0);
    end
    setCtl(5, 8'h00);

    // R4 rising edge with exact latency, R5 sticky and clear
    setCtl(40, 8'h28);
    srcIn[40] = 1'b1;
    waitCyc(2);
    check("R4 rise not yet", 32'(irqReq), 0);
    waitCyc(1);
    check("R4 rise recorded", 32'(irqReq), 1);
    srcIn[40] = 1'b0;
    waitCyc(4);
    check("R5 sticky after input low", 32'(irqReq), 1);
    busRead(8'h84, rd); check("R5 stat word bit8", rd, 32'h0000_0100);
    busWrite(8'h84, 32'h0000_0100, 4'b0001);
    busRead(8'h84, rd); check("R5 wrong lane ignored", rd, 32'h0000_0100);
    busWrite(8'h84, 32'h0000_0100, 4'b0010);
    waitCyc(1);
    check("R5 cleared irq", 32'(irqReq), 0);
    busRead(8'h84, rd); check("R5 cleared stat", rd, 0);
    setCtl(40, 8'h00);

    // R4 falling only
    setCtl(41, 8'h48);
    srcIn[41] = 1'b1;
    waitCyc(4);
    check("R4 fall ignores rise", 32'(irqReq), 0);
    srcIn[41] = 1'b0;
    waitCyc(4);
    check("R4 fall recorded", 32'(irqReq), 1);
    busWrite(8'h84, 32'h0000_0200, 4'hF);
    waitCyc(1);
    check("R5 fall cleared", 32'(irqReq), 0);
    setCtl(41, 8'h00);

    // R4 both edges
    setCtl(42, 8'h68);
    srcIn[42] = 1'b1;
    waitCyc(4);
    check("R4 both rise", 32'(irqReq), 1);
    busWrite(8'h84, 32'h0000_0400, 4'hF);
    waitCyc(1);
    check("R4 both cleared", 32'(irqReq), 0);
    srcIn[42] = 1'b0;
    waitCyc(4);
    check("R4 both fall", 32'(irqReq), 1);
    busWrite(8'h84, 32'h0000_0400, 4'hF);
    setCtl(42, 8'h00);

    // R4 edge recorded while disabled
    setCtl(20, 8'h20);
    srcIn[20] = 1'b1;
    waitCyc(2);
    srcIn[20] = 1'b0;
    waitCyc(4);
    check("R11 disabled edge no irq", 32'(irqReq), 0);
    statBit(20, b); check("R4 disabled edge recorded", 32'(b), 1);
    setCtl(20, 8'h28);
    waitCyc(1);
    check("R4 enable after edge", 32'(irqReq), 1);
    busWrite(8'h80, 32'h0010_0000, 4'hF);
    setCtl(20, 8'h00);

    // R5 clear write to level bit ignored
    setCtl(7, 8'h08);
    srcIn[7] = 1'b1;
    waitCyc(4);
    busWrite(8'h80, 32'h0000_0080, 4'hF);
    waitCyc(1);
    check("R5 level clear ignored irq", 32'(irqReq), 1);
    statBit(7, b); check("R5 level clear ignored stat", 32'(b), 1);
    clearAll();

    // R7 fixed priority among several sources
    for (int k = 0; k < 3; k++) begin
      setCtl(pend[k], 8'h08);
      srcIn[pend[k]] = 1'b1;
    end
    waitCyc(4);
    for (int k = 0; k < 3; k++) begin
      busRead(8'h00, rd); check("R7 fixed lowest wins", rd, 3);
    end

    // R9 rotation: last reported is 3
    busWrite(8'h20, 32'h0000_0040, 4'h1);
    busRead(8'h20, rd); check("R10 prio irq readback", rd, 32'h40);
    last = 3;
    for (int k = 0; k < 7; k++) begin
      expW = pend[0];
      for (int j = 2; j >= 0; j--) if (pend[j] > last) expW = pend[j];
      busRead(8'h00, rd); check("R9 rotating order", rd, 32'(expW));
      last = expW;
    end
    // a non-acknowledging poll of another address keeps the order
    busRead(8'h80, rd); check("R9 stat while rotating", rd, 32'h0000_0408);
    busWrite(8'h20, 32'h0, 4'h1);
    busRead(8'h00, rd); check("R9 rotation off fixed again", rd, 3);
    clearAll();

    // R8 sentinel ambiguity resolved by top status bit
    busRead(8'h00, rd); check("R8 idle winner", rd, 63);
    busRead(8'h84, rd); check("R8 idle bit31", 32'(rd[31]), 0);
    setCtl(63, 8'h08);
    srcIn[63] = 1'b1;
    waitCyc(4);
    check("R8 src63 irq", 32'(irqReq), 1);
    busRead(8'h00, rd); check("R8 src63 winner", rd, 63);
    busRead(8'h84, rd); check("R8 src63 bit31", 32'(rd[31]), 1);
    clearAll();

    // R10 fast priority register and unmapped addresses
    busWrite(8'h24, 32'hFFFF_FFFF, 4'h1);
    busRead(8'h24, rd); check("R10 prio fiq readback", rd, 32'h7F);
    busWrite(8'h24, 32'h0, 4'h2);
    busRead(8'h24, rd); check("R10 prio fiq lane1 ignored", rd, 32'h7F);
    busRead(8'h10, rd); check("R10 unmapped read", rd, 0);
    busRead(8'hC0, rd); check("R10 unmapped high", rd, 0);

    $display("  CHECKS %0d ERRORS %0d", nChk, nErr);
    $finish;
  end

endmodule